// File: doc/BRIEF.md
# Address-Routed Star Packet Switch

This block is the hub of a star network. It joins one host port to sixteen processing-element ports. All traffic passes through it: host to element, element to host, and element to element. Each port has an inbound and an outbound channel of the same shape:

| Field | Width | Meaning |
|-------|-------|---------|
| valid | 1 | a packet is present |
| destination address | 8 | where the packet goes |
| source address | 8 | who sent it |
| kind | 2 | configuration, pattern/target, product or error difference; passed through, never decoded |
| data word | 16 | payload |

Every port can present a packet and receive a packet in the same cycle. Nothing is serialized.

Routing is fully parallel and has no arbiter. The system schedules traffic so that each destination has at most one sender per cycle, for example by sending to a forward neighbour. The switch checks that rule instead of resolving conflicts:
- A destination claimed by more than one packet in a cycle receives none of them.
- The first such event is latched in a sticky flag, together with the index of the destination.
- Packets addressed to an unpopulated address are discarded and counted.

Element port `i` has address `i`. The host port sits at port index 16 and has the reserved address 0xFF. The address field is 8 bits wide, so the element count can grow to the address space limit without changing the packet format.

Top module: `star_pkt_switch`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any clock edge sampled with reset high, every outbound valid is low, the collision flag is low and the discard counter is zero.
- R2: A packet presented at clock edge k appears on its outbound port just after edge k+2. Its destination, source, kind and data fields are unchanged, and every packet sees this same latency.
- R3: A packet with destination address d, where d is in 0..15, is delivered on element port d only. Each outbound packet carries that port's own address in its destination field.
- R4: Packets from all 17 ports in one cycle, each to a distinct destination, are all delivered in the same output cycle.
- R5: A packet from any port with destination 0xFF is delivered on the host port, which is port index 16.
- R6: When two or more valid packets name the same destination in one cycle, no packet is delivered to that destination for that cycle. Other destinations in the same cycle are delivered normally.
- R7: The first collision sets the collision flag in the same output cycle as the dropped packets. It also records the lowest-numbered colliding destination index of that cycle, where the host is index 16. The flag and the index then hold until reset.
- R8: A valid packet whose destination is neither 0..15 nor 0xFF is discarded. The 8-bit discard counter rises by the number of such packets in that cycle and saturates at 255.
- R9: An inbound channel with valid low has no effect on any output, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 17 | Inbound valid per port; bit 16 is the host |
| in_dst | input | 136 | Inbound destination address, 8 bits per port, port p at bits [8p+7:8p] |
| in_src | input | 136 | Inbound source address, 8 bits per port |
| in_typ | input | 34 | Inbound packet kind, 2 bits per port |
| in_dat | input | 272 | Inbound data word, 16 bits per port |
| out_vld | output | 17 | Outbound valid per port |
| out_dst | output | 136 | Outbound destination address per port |
| out_src | output | 136 | Outbound source address per port |
| out_typ | output | 34 | Outbound packet kind per port |
| out_dat | output | 272 | Outbound data word per port |
| coll_flag | output | 1 | Sticky collision flag |
| coll_idx | output | 5 | Destination index of the first collision |
| err_cnt | output | 8 | Saturating count of discarded out-of-range packets |

## Verification
A corrupted first-stage register or a wrong decode shows at the outbound ports exactly two cycles after the packet enters. It appears as one of three symptoms:
- a valid pulse on the wrong port;
- a missing pulse where one was expected;
- a field that differs from the field sent.

A bad collision or discard update shows in that same output cycle on the flag, the index or the counter. Because the flag and the counter hold their state, a single wrong update remains visible at the ports until the next reset. For that reason, the outputs are compared with the model on every cycle.

// File: rtl/star_pkt_switch.sv
module star_pkt_switch #(
  parameter int NPE = 16,
  parameter int AW  = 8,
  parameter int TW  = 2,
  parameter int DW  = 16,
  parameter int CW  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPE:0]                 in_vld,
  input  logic [(NPE+1)*AW-1:0]        in_dst,
  input  logic [(NPE+1)*AW-1:0]        in_src,
  input  logic [(NPE+1)*TW-1:0]        in_typ,
  input  logic [(NPE+1)*DW-1:0]        in_dat,
  output logic [NPE:0]                 out_vld,
  output logic [(NPE+1)*AW-1:0]        out_dst,
  output logic [(NPE+1)*AW-1:0]        out_src,
  output logic [(NPE+1)*TW-1:0]        out_typ,
  output logic [(NPE+1)*DW-1:0]        out_dat,
  output logic                         coll_flag,
  output logic [$clog2(NPE+1)-1:0]     coll_idx,
  output logic [CW-1:0]                err_cnt
);
  localparam int NP = NPE + 1;
  localparam int HOST = NPE;
  localparam int IW = $clog2(NP);
  localparam logic [AW-1:0] HOST_ADDR = {AW{1'b1}};

  logic [NP-1:0] s1_vld;
  logic [AW-1:0] s1_dst [NP];
  logic [AW-1:0] s1_src [NP];
  logic [TW-1:0] s1_typ [NP];
  logic [DW-1:0] s1_dat [NP];

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= '0;
    else     s1_vld <= in_vld;
    for (int i = 0; i < NP; i++) begin
      s1_dst[i] <= in_dst[i*AW +: AW];
      s1_src[i] <= in_src[i*AW +: AW];
      s1_typ[i] <= in_typ[i*TW +: TW];
      s1_dat[i] <= in_dat[i*DW +: DW];
    end
  end

  logic [NP-1:0] good;
  logic [IW-1:0] tgt [NP];

  always_comb begin
    for (int s = 0; s < NP; s++) begin
      good[s] = s1_vld[s] && (s1_dst[s] == HOST_ADDR || int'(s1_dst[s]) < NPE);
      tgt[s]  = (s1_dst[s] == HOST_ADDR) ? IW'(HOST) : IW'(s1_dst[s]);
    end
  end

  logic [NP-1:0] hit [NP];
  logic [NP-1:0] deliver, clash;
  logic [AW-1:0] m_dst [NP];
  logic [AW-1:0] m_src [NP];
  logic [TW-1:0] m_typ [NP];
  logic [DW-1:0] m_dat [NP];

  always_comb begin
    for (int d = 0; d < NP; d++) begin
      m_dst[d] = '0;
      m_src[d] = '0;
      m_typ[d] = '0;
      m_dat[d] = '0;
      for (int s = 0; s < NP; s++) begin
        hit[d][s] = good[s] && (tgt[s] == IW'(d));
        if (hit[d][s]) begin
          m_dst[d] = m_dst[d] | s1_dst[s];
          m_src[d] = m_src[d] | s1_src[s];
          m_typ[d] = m_typ[d] | s1_typ[s];
          m_dat[d] = m_dat[d] | s1_dat[s];
        end
      end
      deliver[d] = $onehot(hit[d]);
      clash[d]   = (|hit[d]) && !deliver[d];
    end
  end

  logic [IW-1:0] first;
  always_comb begin
    first = '0;
    for (int d = NP - 1; d >= 0; d--)
      if (clash[d]) first = IW'(d);
  end

  logic [IW:0] nbad;
  logic [CW:0] sum;
  assign nbad = (IW+1)'($countones(s1_vld & ~good));
  assign sum  = {1'b0, err_cnt} + (CW+1)'(nbad);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= '0;
      coll_flag <= 1'b0;
      coll_idx  <= '0;
      err_cnt   <= '0;
    end else begin
      out_vld <= deliver;
      if (!coll_flag && |clash) begin
        coll_flag <= 1'b1;
        coll_idx  <= first;
      end
      err_cnt <= sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < NP; d++) begin
      out_dst[d*AW +: AW] <= m_dst[d];
      out_src[d*AW +: AW] <= m_src[d];
      out_typ[d*TW +: TW] <= m_typ[d];
      out_dat[d*DW +: DW] <= m_dat[d];
    end
  end
endmodule

// File: rtl/star_pkt_switch_chk.sv
module star_pkt_switch_chk #(
  parameter int NPE = 16,
  parameter int AW  = 8,
  parameter int CW  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NPE:0]             in_vld,
  input logic [NPE:0]             out_vld,
  input logic [(NPE+1)*AW-1:0]    out_dst,
  input logic                     coll_flag,
  input logic [$clog2(NPE+1)-1:0] coll_idx,
  input logic [CW-1:0]            err_cnt
);
  localparam int NP = NPE + 1;

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (out_vld == '0 && !coll_flag && err_cnt == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && |out_vld) |-> $past(|in_vld, 2));

  for (genvar d = 0; d < NP; d++) begin : g_port
    localparam logic [AW-1:0] PA = (d == NPE) ? {AW{1'b1}} : AW'(d);
    p_dst_match_r3: assert property (@(posedge clk) disable iff (rst)
      out_vld[d] |-> out_dst[d*AW +: AW] == PA);
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    coll_flag |=> (coll_flag && $stable(coll_idx)));

  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    coll_flag |-> int'(coll_idx) < NP);

  p_cnt_mono_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1) |-> err_cnt >= $past(err_cnt));
endmodule

bind star_pkt_switch star_pkt_switch_chk #(.NPE(NPE), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld), .out_dst(out_dst),
  .coll_flag(coll_flag), .coll_idx(coll_idx), .err_cnt(err_cnt));

// File: tb/test_star_pkt_switch.sv
`timescale 1ns/1ps
module test_star_pkt_switch;
  localparam int NPE = 16, NP = 17, AW = 8, TW = 2, DW = 16, CW = 8, IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NP-1:0]    in_vld, out_vld;
  logic [NP*AW-1:0] in_dst, in_src, out_dst, out_src;
  logic [NP*TW-1:0] in_typ, out_typ;
  logic [NP*DW-1:0] in_dat, out_dat;
  logic             coll_flag;
  logic [IW-1:0]    coll_idx;
  logic [CW-1:0]    err_cnt;

  star_pkt_switch i_star_pkt_switch (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_src(in_src),
    .in_typ(in_typ), .in_dat(in_dat), .out_vld(out_vld), .out_dst(out_dst),
    .out_src(out_src), .out_typ(out_typ), .out_dat(out_dat),
    .coll_flag(coll_flag), .coll_idx(coll_idx), .err_cnt(err_cnt));

  bit iv [NP];
  int idst [NP], isrc [NP], ityp [NP], idat [NP];

  int m_cnt, m_idx;
  bit m_flag;
  bit e_vld [2][NP];
  int e_dst [2][NP], e_src [2][NP], e_typ [2][NP], e_dat [2][NP];
  bit e_flag [2];
  int e_idx [2], e_cnt [2];

  int errors = 0, checks = 0;
  string tag = "R1";
  bit armed = 0, done = 0;

  function automatic int tidx(int a);
    if (a == 255) return 16;
    if (a < 16) return a;
    return -1;
  endfunction

  task automatic clear_in();
    for (int s = 0; s < NP; s++) begin
      iv[s] = 0; idst[s] = 0; isrc[s] = 0; ityp[s] = 0; idat[s] = 0;
    end
  endtask

  task automatic drive();
    for (int s = 0; s < NP; s++) begin
      in_vld[s] = iv[s];
      in_dst[s*AW +: AW] = AW'(idst[s]);
      in_src[s*AW +: AW] = AW'(isrc[s]);
      in_typ[s*TW +: TW] = TW'(ityp[s]);
      in_dat[s*DW +: DW] = DW'(idat[s]);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_flag = 0; m_idx = 0;
    for (int k = 0; k < 2; k++) begin
      e_flag[k] = 0; e_idx[k] = 0; e_cnt[k] = 0;
      for (int d = 0; d < NP; d++) begin
        e_vld[k][d] = 0; e_dst[k][d] = 0; e_src[k][d] = 0; e_typ[k][d] = 0; e_dat[k][d] = 0;
      end
    end
  endtask

  task automatic model_push();
    int n [NP];
    int nb = 0;
    e_flag[1] = e_flag[0]; e_idx[1] = e_idx[0]; e_cnt[1] = e_cnt[0];
    for (int d = 0; d < NP; d++) begin
      e_vld[1][d] = e_vld[0][d]; e_dst[1][d] = e_dst[0][d]; e_src[1][d] = e_src[0][d];
      e_typ[1][d] = e_typ[0][d]; e_dat[1][d] = e_dat[0][d];
      n[d] = 0;
    end
    for (int s = 0; s < NP; s++)
      if (iv[s]) begin
        if (tidx(idst[s]) >= 0) n[tidx(idst[s])]++;
        else nb++;
      end
    for (int d = 0; d < NP; d++) begin
      e_vld[0][d] = (n[d] == 1);
      for (int s = 0; s < NP; s++)
        if (n[d] == 1 && iv[s] && tidx(idst[s]) == d) begin
          e_dst[0][d] = idst[s]; e_src[0][d] = isrc[s];
          e_typ[0][d] = ityp[s]; e_dat[0][d] = idat[s];
        end
    end
    m_cnt = (m_cnt + nb > 255) ? 255 : m_cnt + nb;
    if (!m_flag)
      for (int d = NP - 1; d >= 0; d--)
        if (n[d] > 1) begin m_flag = 1; m_idx = d; end
    e_flag[0] = m_flag; e_idx[0] = m_idx; e_cnt[0] = m_cnt;
  endtask

  task automatic compare();
    bit bad = 0;
    checks++;
    for (int d = 0; d < NP && !bad; d++) begin
      if (out_vld[d] !== e_vld[1][d]) begin
        bad = 1;
        $display("FAIL %s port %0d valid: actual %b expected %b", tag, d, out_vld[d], e_vld[1][d]);
      end else if (e_vld[1][d] &&
                   (int'(out_dst[d*AW +: AW]) != e_dst[1][d] || int'(out_src[d*AW +: AW]) != e_src[1][d] ||
                    int'(out_typ[d*TW +: TW]) != e_typ[1][d] || int'(out_dat[d*DW +: DW]) != e_dat[1][d])) begin
        bad = 1;
        $display("FAIL %s port %0d fields: actual %h/%h/%h/%h expected %h/%h/%h/%h", tag, d,
                 out_dst[d*AW +: AW], out_src[d*AW +: AW], out_typ[d*TW +: TW], out_dat[d*DW +: DW],
                 e_dst[1][d], e_src[1][d], e_typ[1][d], e_dat[1][d]);
      end
    end
    if (bad) errors++;
    checks++;
    if (coll_flag !== e_flag[1] || (e_flag[1] && int'(coll_idx) != e_idx[1]) || int'(err_cnt) != e_cnt[1]) begin
      errors++;
      $display("FAIL %s status flag/idx/cnt: actual %b/%0d/%0d expected %b/%0d/%0d", tag,
               coll_flag, coll_idx, err_cnt, e_flag[1], e_idx[1], e_cnt[1]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (armed) compare();
    model_push();
    drive();
  endtask

  task automatic do_reset();
    armed = 0;
    rst = 1;
    clear_in();
    drive();
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (out_vld !== '0 || coll_flag !== 1'b0 || err_cnt !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual vld=%h flag=%b cnt=%0d expected 0/0/0", out_vld, coll_flag, err_cnt);
    end
    model_clear();
    rst = 0;
    armed = 1;
  endtask

  task automatic fwd(int k);
    clear_in();
    for (int s = 0; s < NPE; s++) begin
      iv[s] = 1; idst[s] = (s + 1) % NPE; isrc[s] = s;
      ityp[s] = (s + k) % 4; idat[s] = (s * 257 + k * 4099) & 16'hFFFF;
    end
  endtask

  initial begin
    clear_in();
    drive();
    do_reset();

    tag = "R3";
    for (int k = 0; k < 4; k++) begin fwd(k); step(); end
    clear_in();
    for (int s = 0; s < 4; s++) begin iv[s] = 1; idst[s] = s + 1; isrc[s] = s; idat[s] = 16'hA000 + s; end
    iv[16] = 1; idst[16] = 9; isrc[16] = 255; ityp[16] = 0; idat[16] = 16'h1234;
    step();

    tag = "R5";
    fwd(7); iv[7] = 1; idst[7] = 255; idat[7] = 16'hBEEF; step();
    clear_in(); iv[0] = 1; idst[0] = 255; isrc[0] = 0; ityp[0] = 3; idat[0] = 16'h0F0F; step();

    tag = "R4";
    for (int k = 1; k <= 4; k++) begin
      clear_in();
      for (int s = 0; s < NP; s++) begin
        int di = (s * 5 + k) % NP;
        iv[s] = 1; idst[s] = (di == 16) ? 255 : di; isrc[s] = (s == 16) ? 255 : s;
        ityp[s] = k % 4; idat[s] = (s * 911 + k * 37) & 16'hFFFF;
      end
      step();
    end

    tag = "R9";
    clear_in();
    for (int s = 0; s < NP; s++) begin idst[s] = s % 3 == 0 ? 200 : s; idat[s] = 16'hDEAD; end
    step(); step();
    fwd(9); iv[3] = 0; iv[10] = 0; idst[3] = 77; step();

    tag = "R6";
    clear_in();
    iv[2] = 1; idst[2] = 6; isrc[2] = 2; idat[2] = 16'h0202;
    iv[9] = 1; idst[9] = 6; isrc[9] = 9; idat[9] = 16'h0909;
    iv[3] = 1; idst[3] = 3; isrc[3] = 3; idat[3] = 16'h0303;
    iv[11] = 1; idst[11] = 3; isrc[11] = 11; idat[11] = 16'h1111;
    iv[0] = 1; idst[0] = 1; isrc[0] = 0; idat[0] = 16'h0001;
    step();
    tag = "R7";
    clear_in();
    iv[4] = 1; idst[4] = 1; isrc[4] = 4;
    iv[8] = 1; idst[8] = 1; isrc[8] = 8;
    iv[12] = 1; idst[12] = 4; isrc[12] = 12; idat[12] = 16'h4C4C;
    step();
    clear_in(); step(); step();

    tag = "R8";
    fwd(3);
    idst[0] = 16; idst[1] = 200; idst[2] = 254;
    step();
    clear_in(); step(); step();
    for (int k = 0; k < 16; k++) begin
      clear_in();
      for (int s = 0; s < NP; s++) begin iv[s] = 1; idst[s] = 100 + k; isrc[s] = s; end
      step();
    end
    fwd(5); idst[6] = 16; step();
    clear_in(); step(); step();

    tag = "R1";
    do_reset();
    tag = "R2";
    for (int k = 0; k < 40; k++) begin
      clear_in();
      for (int s = 0; s < NP; s++) begin
        int r = int'($urandom_range(0, 19));
        iv[s] = ($urandom_range(0, 3) != 0);
        idst[s] = (r == 17) ? 255 : (r == 18) ? 33 : (r == 19) ? 250 : (r % 16);
        isrc[s] = (s == 16) ? 255 : s;
        ityp[s] = int'($urandom_range(0, 3));
        idat[s] = int'($urandom_range(0, 65535));
      end
      step();
    end
    clear_in(); step(); step(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual not finished expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule